// File: doc/BRIEF.md
# Four-Beat Burst Address Sequencer

This block produces the internal address for a four-beat memory burst. When an access starts, a load strobe captures the full start address. From then on, only the lowest bits of the address move, and they follow one of two fixed orders. In linear order the beat offset is added modulo four. In interleaved order the beat offset is XORed into the start value. The upper bits stay exactly as they were loaded.

An active-low advance strobe steps the sequence one beat on each clock edge where it is low. While the strobe is high the current address holds, which stretches the present data beat for as long as needed. After the fourth beat the sequence returns to its starting value and repeats. A new load can arrive in the middle of a burst. It always wins over advance and restarts the sequence. The order-select input is a static configuration pin that system integration ties off. It is expected to change only while no burst is in progress.

Top module: `qbs_burst_seq`

## Requirements
- R1: While rst_n is low at a rising edge, the block clears its state, so from the following cycle addr_o is all zeros.
- R2: A rising edge with load_i high loads load_addr_i as the start address and resets the beat offset to 0. From the next cycle addr_o equals load_addr_i.
- R3: addr_o bits [ADDR_W-1:2] change only on a load edge. At all other times they equal the upper bits of the last loaded address.
- R4: With order_ilv_i = 1 (interleaved), addr_o[1:0] = start[1:0] XOR beat. For example, start 01 gives 01, 00, 11, 10.
- R5: With order_ilv_i = 0 (linear), addr_o[1:0] = (start[1:0] + beat) mod 4. For example, start 01 gives 01, 10, 11, 00.
- R6: A rising edge with load_i low and adv_n_i low increases the beat offset by one. addr_o shows the new beat in the next cycle.
- R7: A rising edge with load_i low and adv_n_i high leaves addr_o unchanged.
- R8: Advancing from beat 3 wraps the offset to 0, so addr_o returns to the loaded start address and the order repeats.
- R9: When load_i and adv_n_i are both active at the same edge, the load takes effect. The next cycle shows the new start address at beat 0, with no advance applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous reset, active low |
| load_i | input | 1 | Starts a new burst from load_addr_i |
| load_addr_i | input | ADDR_W | Full start address |
| adv_n_i | input | 1 | Beat advance, active low |
| order_ilv_i | input | 1 | Static order select: 1 interleaved, 0 linear |
| addr_o | output | ADDR_W | Current internal address |

## Verification
Every result appears one clock after the edge that causes it. A reset, load, advance or hold sampled at edge k is visible on addr_o from just after edge k until edge k+1. The output comes from registers through a small combinational map, so there is no added latency. The bench drives inputs on the falling edge and samples 1 ns after each rising edge. It compares against a beat model advanced by exactly one step for each edge. The sweep covers every start value in both orders, with holds placed mid-burst, full wraps, and a reload that collides with an active advance.

// File: rtl/qbs_pkg.sv
// Package: shared types for the burst address sequencer.
// Assumes: order select is encoded as one bit, 1 meaning interleaved.
package qbs_pkg;

    typedef enum logic {
        ORDER_LINEAR      = 1'b0,
        ORDER_INTERLEAVED = 1'b1
    } burst_order_e;

endpackage

// File: rtl/qbs_base_reg.sv
// Module: qbs_base_reg
// Holds the start address of the current burst.
// Assumes: load_i is a single-cycle request; synchronous active-low reset.
module qbs_base_reg #(
    parameter int ADDR_W = 18
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic [ADDR_W-1:0] load_addr_i,
    output logic [ADDR_W-1:0] base_o
);

    logic [ADDR_W-1:0] base_q;

    // Capture the start address when a new burst begins.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q <= '0;
        end else if (load_i) begin
            base_q <= load_addr_i;
        end
    end

    assign base_o = base_q;

endmodule

// File: rtl/qbs_beat_counter.sv
// Module: qbs_beat_counter
// Counts beats within a burst and wraps naturally at 2**BEAT_W.
// Assumes: clear_i wins over step_i; synchronous active-low reset.
module qbs_beat_counter #(
    parameter int BEAT_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear_i,
    input  logic              step_i,
    output logic [BEAT_W-1:0] beat_o
);

    logic [BEAT_W-1:0] beat_q;
    logic [BEAT_W-1:0] beat_inc;

    // Next count, wrapping from the last beat back to zero.
    always_comb begin
        beat_inc = beat_q + {{(BEAT_W-1){1'b0}}, 1'b1};
    end

    // Clear on load, step on advance, otherwise hold.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            beat_q <= '0;
        end else if (clear_i) begin
            beat_q <= '0;
        end else if (step_i) begin
            beat_q <= beat_inc;
        end
    end

    assign beat_o = beat_q;

endmodule

// File: rtl/qbs_order_map.sv
// Module: qbs_order_map
// Maps a start offset and a beat count to the in-burst address bits.
// Assumes: order_i is static during a burst; purely combinational.
module qbs_order_map
    import qbs_pkg::*;
#(
    parameter int BEAT_W = 2
) (
    input  logic [BEAT_W-1:0] start_i,
    input  logic [BEAT_W-1:0] beat_i,
    input  burst_order_e      order_i,
    output logic [BEAT_W-1:0] low_o
);

    logic [BEAT_W-1:0] ilv_low;
    logic [BEAT_W-1:0] lin_low;

    // Interleaved order: each bit of the start value is flipped by the matching beat bit.
    for (genvar b = 0; b < BEAT_W; b++) begin : g_ilv_bit
        assign ilv_low[b] = start_i[b] ^ beat_i[b];
    end

    // Linear order: add the beat to the start value; the carry out is dropped, so it wraps.
    always_comb begin
        lin_low = start_i + beat_i;
    end

    // Pick the order set by the static configuration pin.
    always_comb begin
        if (order_i == ORDER_INTERLEAVED) begin
            low_o = ilv_low;
        end else begin
            low_o = lin_low;
        end
    end

endmodule

// File: rtl/qbs_burst_seq.sv
// Module: qbs_burst_seq (top)
// Produces the internal burst address: upper bits from the loaded start,
// low BEAT_W bits sequenced linearly or interleaved, stepped by adv_n_i.
// Assumes: order_ilv_i is static while bursting; BEAT_W < ADDR_W.
module qbs_burst_seq
    import qbs_pkg::*;
#(
    parameter int ADDR_W = 18,
    parameter int BEAT_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic [ADDR_W-1:0] load_addr_i,
    input  logic              adv_n_i,
    input  logic              order_ilv_i,
    output logic [ADDR_W-1:0] addr_o
);

    localparam int UPPER_W = ADDR_W - BEAT_W;

    logic [ADDR_W-1:0] base;
    logic [BEAT_W-1:0] beat;
    logic [BEAT_W-1:0] low;
    logic              step;
    burst_order_e      order;

    // An advance request counts only when no load arrives at the same edge.
    always_comb begin
        step  = !adv_n_i && !load_i;
        order = burst_order_e'(order_ilv_i);
    end

    qbs_base_reg #(
        .ADDR_W (ADDR_W)
    ) base_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .load_i      (load_i),
        .load_addr_i (load_addr_i),
        .base_o      (base)
    );

    qbs_beat_counter #(
        .BEAT_W (BEAT_W)
    ) cnt_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear_i (load_i),
        .step_i  (step),
        .beat_o  (beat)
    );

    qbs_order_map #(
        .BEAT_W (BEAT_W)
    ) map_i (
        .start_i (base[BEAT_W-1:0]),
        .beat_i  (beat),
        .order_i (order),
        .low_o   (low)
    );

    // Join the unchanged upper bits with the sequenced low bits.
    always_comb begin
        addr_o = {base[ADDR_W-1 -: UPPER_W], low};
    end

endmodule

// File: rtl/qbs_burst_seq_chk.sv
// Module: qbs_burst_seq_chk
// Checks the sequencer at its ports over time; bound to qbs_burst_seq.
// Assumes: order_ilv_i is held steady, as the block requires.
module qbs_burst_seq_chk #(
    parameter int ADDR_W = 18,
    parameter int BEAT_W = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              load_i,
    input logic [ADDR_W-1:0] load_addr_i,
    input logic              adv_n_i,
    input logic              order_ilv_i,
    input logic [ADDR_W-1:0] addr_o
);

    // R2 R9
    load_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> addr_o == $past(load_addr_i));

    // R7
    hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_i && adv_n_i) |=> $stable(addr_o));

    // R3
    upper_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !load_i |=> addr_o[ADDR_W-1:BEAT_W] == $past(addr_o[ADDR_W-1:BEAT_W]));

    // R5
    linear_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_i && !adv_n_i && !order_ilv_i && $stable(order_ilv_i)) |=>
        addr_o[BEAT_W-1:0] == BEAT_W'($past(addr_o[BEAT_W-1:0]) + 1));

    // R4
    ilv_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_i && !adv_n_i && order_ilv_i && $stable(order_ilv_i)) |=>
        addr_o[0] != $past(addr_o[0]));

endmodule

bind qbs_burst_seq qbs_burst_seq_chk #(
    .ADDR_W (ADDR_W),
    .BEAT_W (BEAT_W)
) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .load_i      (load_i),
    .load_addr_i (load_addr_i),
    .adv_n_i     (adv_n_i),
    .order_ilv_i (order_ilv_i),
    .addr_o      (addr_o)
);

// File: tb/qbs_burst_seq_tb.sv
// Bench: sweeps every start offset in both orders with holds, wraps and a colliding reload.
module qbs_burst_seq_tb_top;

    localparam int AW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          load_i = 1'b0;
    logic [AW-1:0] load_addr_i = '0;
    logic          adv_n_i = 1'b1;
    logic          order_ilv_i = 1'b0;
    logic [AW-1:0] addr_o;

    int n_checks = 0;
    int n_errors = 0;
    bit finished = 1'b0;

    int exp_start = 0;
    int exp_upper = 0;
    int exp_beat  = 0;

    always #2 clk = ~clk;

    qbs_burst_seq #(.ADDR_W(AW), .BEAT_W(2)) dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .load_i      (load_i),
        .load_addr_i (load_addr_i),
        .adv_n_i     (adv_n_i),
        .order_ilv_i (order_ilv_i),
        .addr_o      (addr_o)
    );

    task automatic check(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic int low_exp();
        if (order_ilv_i) return exp_start ^ exp_beat;
        return (exp_start + exp_beat) % 4;
    endfunction

    // Apply one edge of stimulus, update the model, and check just after the edge.
    task automatic step(input bit ld, input int a, input bit adv_n, input string tag);
        @(negedge clk);
        load_i      = ld;
        load_addr_i = AW'(a);
        adv_n_i     = adv_n;
        @(posedge clk);
        #1;
        if (ld) begin
            exp_start = a % 4;
            exp_upper = a / 4;
            exp_beat  = 0;
        end else if (!adv_n) begin
            exp_beat = (exp_beat + 1) % 4;
        end
        check("R3 upper bits", int'(addr_o[AW-1:2]), exp_upper);
        check(tag, int'(addr_o[1:0]), low_exp());
    endtask

    initial begin
        #(4 * 100000);
        if (!finished) begin
            n_errors++;
            n_checks++;
            $display("FAIL watchdog actual=running expected=done");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

    initial begin
        bit adv_pat [10] = '{0, 0, 1, 0, 1, 1, 0, 0, 0, 0};
        repeat (3) @(posedge clk);
        #1;
        check("R1 reset address", int'(addr_o), 0);
        @(negedge clk);
        rst_n = 1'b1;
        for (int m = 0; m < 2; m++) begin
            order_ilv_i = m[0];
            for (int s = 0; s < 4; s++) begin
                int up = (s * 13 + m * 29 + 5) % 64;
                step(1'b1, up * 4 + s, 1'b1, "R2 load start");
                for (int k = 0; k < 10; k++) begin
                    string tag;
                    if (adv_pat[k]) tag = "R7 hold";
                    else if (exp_beat == 3) tag = "R8 wrap";
                    else tag = m ? "R6 R4 interleaved" : "R6 R5 linear";
                    step(1'b0, 0, adv_pat[k], tag);
                end
                // Mid-burst reload colliding with an active advance.
                step(1'b1, ((up + 7) % 64) * 4 + (3 - s), 1'b0, "R9 reload priority");
                step(1'b0, 0, 1'b0, m ? "R6 R4 after reload" : "R6 R5 after reload");
            end
        end
        // Known sequences from start 01 in both orders.
        order_ilv_i = 1'b1;
        step(1'b1, 1, 1'b1, "R2 load 01");
        step(1'b0, 0, 1'b0, "R4 beat1");
        check("R4 interleaved 01->00", int'(addr_o[1:0]), 0);
        order_ilv_i = 1'b0;
        step(1'b1, 1, 1'b1, "R2 load 01");
        step(1'b0, 0, 1'b0, "R5 beat1");
        check("R5 linear 01->10", int'(addr_o[1:0]), 2);
        @(negedge clk);
        rst_n = 1'b0;
        @(posedge clk);
        #1;
        check("R1 reset mid-run", int'(addr_o), 0);
        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

endmodule